// File: doc/BRIEF.md
# Priority Queue Scanner with Current Priority Register

This block picks the most urgent pending event among up to eight per-priority event queues, and it keeps the processor's current priority register. A bit vector of pending priorities is kept inside the block. Upstream logic ORs new bits into it. Index 0 is the most urgent priority. A scan request starts a small state machine that probes the queues one at a time, in order of rising index. Each probe takes one cycle. The machine stops at the first queue that offers a nonzero head entry. Along the way it clears the pending bit of every queue it finds empty and signals that queue to fold its pending-release count into its occupancy. When it stops, it reports the entry and rewrites the current priority register.

A scan runs in one of two modes. A consuming scan removes the entry it returns. A peek scan leaves every queue pointer alone but still clears pending bits and updates the register. A peek scan is issued after an end-of-interrupt, and a replay pulse tells the processor that more work is waiting. Software may also write the current priority register directly. A value of 0x00 shuts interrupt delivery and 0xFF opens it for every priority. The queue storage sits outside this block. Each queue presents its head entry, or zero when it is empty, and accepts a pop strobe and a drain strobe.

Top module: `prio_scan_top`

## Requirements
- R1: After reset the pending vector is 0, the current priority register is 0x00, and done, busy, replay and irq are all low.
- R2: A cycle with `pend_set_vld_i` high ORs `pend_set_mask_i` into the pending vector, and the result is visible on `pend_mask_o` after the next clock edge.
- R3: A scan probes the set pending bits from the lowest index upward, one queue per cycle, with at most one probe bit high. It stops at the first queue whose head entry is nonzero. `scan_done_o` rises for one cycle with that entry on `scan_result_o`, exactly E+2 cycles after the start is sampled, where E is the number of empty queues probed.
- R4: A probed queue with a zero head entry has its pending bit cleared and receives a one-cycle `q_drain_o` strobe, and the scan moves on to the next set bit.
- R5: When no set bit leads to an entry, the result is 0 and the current priority register becomes 0xFF.
- R6: When an entry is found at priority p, the register becomes p. `cur_prio_upd_o` pulses together with done only when the register value actually changed.
- R7: A consuming scan (`scan_peek_i` = 0) pops exactly the queue it found. A peek scan (`scan_peek_i` = 1) pops nothing, but it still clears empty queues' bits and updates the register.
- R8: `replay_o` pulses together with done when, and only when, a peek scan returns a nonzero entry.
- R9: A direct write through `cur_prio_wr_i` takes effect after the next edge. It wins over a scan update at the same edge, and in that case `cur_prio_upd_o` stays low.
- R10: `irq_o` is high exactly when some pending bit p has p below the register value. A value of 0x00 therefore blocks all delivery and 0xFF allows it for any pending priority.
- R11: A start request that arrives while a scan is running is ignored. No second scan or done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pend_set_vld_i | input | 1 | OR the set mask into the pending vector |
| pend_set_mask_i | input | NPRIO | Pending bits to add |
| scan_start_i | input | 1 | Request a scan (taken only when idle) |
| scan_peek_i | input | 1 | 1 = peek scan, 0 = consuming scan; sampled with the start |
| q_entry_i | input | NPRIO*ENTRY_W | Head entry of each queue, zero when empty; queue p at bits [p*ENTRY_W +: ENTRY_W] |
| q_probe_o | output | NPRIO | One-hot probe of the queue examined this cycle |
| q_pop_o | output | NPRIO | Remove the head entry of this queue at the clock edge |
| q_drain_o | output | NPRIO | Queue seen empty: fold its release count into its occupancy |
| cur_prio_wr_i | input | 1 | Direct write of the current priority register |
| cur_prio_wdata_i | input | 8 | Value for the direct write |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle pulse when a scan ends |
| scan_result_o | output | ENTRY_W | Entry found by the last scan, 0 if none |
| replay_o | output | 1 | Peek scan found work; pulses with done |
| pend_mask_o | output | NPRIO | Current pending vector |
| cur_prio_o | output | 8 | Current priority register |
| cur_prio_upd_o | output | 1 | Scan changed the register at this done |
| irq_o | output | 1 | A pending priority is more urgent than the register |

## Verification
The bench models the queues as counters. It builds patterns in which stale pending bits sit below the live queue, so a scan that stops too early, skips a bit or probes the wrong way would return the wrong entry or take the wrong number of cycles. Peek scans are checked for entries that were popped anyway, for pending bits that were never cleared, and for a missing replay. A scan whose register value does not change is checked for a false update pulse. A direct register write that lands on the same edge as the end of a scan, a start request made while busy, and register values of 0x00, 0xFF and values between them against the pending vector all expose ordering and comparison errors at the ports.

// File: rtl/prio_scan_pkg.sv
package prio_scan_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          PRIO_REG_W = 8;
  localparam logic [7:0]  PRIO_OPEN  = 8'hFF;
  localparam logic [7:0]  PRIO_SHUT  = 8'h00;

  typedef enum logic {
    SC_IDLE  = 1'b0,
    SC_PROBE = 1'b1
  } scan_st_e;
endpackage

// File: rtl/prio_scan_rst_sync.sv
module prio_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/prio_scan_lowest.sv
module prio_scan_lowest #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // Walk from index 0 upward; the first set bit is the most urgent.
  always_comb begin
    logic seen;
    seen     = 1'b0;
    onehot_o = '0;
    idx_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !seen) begin
        onehot_o[i] = 1'b1;
        idx_o       = IW'(i);
      end
      seen = seen | req_i[i];
    end
    any_o = seen;
  end
endmodule

// File: rtl/prio_scan_curprio.sv
module prio_scan_curprio
  import prio_scan_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_wr_i,
  input  logic [PRIO_REG_W-1:0] sw_val_i,
  input  logic                  hw_wr_i,
  input  logic [PRIO_REG_W-1:0] hw_val_i,
  input  logic [N-1:0]          pend_i,
  output logic [PRIO_REG_W-1:0] cur_o,
  output logic                  hw_chg_o,
  output logic                  irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PRIO_REG_W-1:0] cur_q, cur_d;
  logic                  chg_q, chg_d;
  logic                  cur_en;
  logic [N-1:0]          urgent;

  // Software write has precedence; a scan writes only on a real change.
  always_comb begin
    cur_d  = cur_q;
    chg_d  = 1'b0;
    cur_en = 1'b0;
    if (sw_wr_i) begin
      cur_d  = sw_val_i;
      cur_en = 1'b1;
    end else if (hw_wr_i && (hw_val_i != cur_q)) begin
      cur_d  = hw_val_i;
      chg_d  = 1'b1;
      cur_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= PRIO_SHUT;
      chg_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  // One comparator per priority level.
  for (genvar g = 0; g < N; g++) begin : g_urgent
    assign urgent[g] = pend_i[g] && (PRIO_REG_W'(g) < cur_q);
  end

  assign cur_o    = cur_q;
  assign hw_chg_o = chg_q;
  assign irq_o    = |urgent;

  p_upd_changed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (cur_q != $past(cur_q)));

  p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_wr_i) |-> ((cur_q == $past(sw_val_i)) && !chg_q));

  p_shut_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == PRIO_SHUT) |-> !irq_o);
endmodule

// File: rtl/prio_scan_fsm.sv
module prio_scan_fsm
  import prio_scan_pkg::*;
#(
  parameter int N  = 8,
  parameter int EW = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  peek_i,
  input  logic                  set_vld_i,
  input  logic [N-1:0]          set_mask_i,
  input  logic [N*EW-1:0]       entries_i,
  output logic [N-1:0]          pend_o,
  output logic [N-1:0]          probe_o,
  output logic [N-1:0]          pop_o,
  output logic [N-1:0]          drain_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [EW-1:0]         result_o,
  output logic                  replay_o,
  output logic                  hw_wr_o,
  output logic [PRIO_REG_W-1:0] hw_val_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  scan_st_e      st_q, st_d;
  logic          peek_q, peek_en;
  logic [N-1:0]  pend_q, pend_d;
  logic          done_q, replay_q;
  logic [EW-1:0] result_q, result_d;
  logic          finish;

  logic          any_pend;
  logic [N-1:0]  low_oh;
  logic [IW-1:0] low_idx;
  logic [EW-1:0] head;

  prio_scan_lowest #(.N(N), .IW(IW)) u_lowest (
    .req_i    (pend_q),
    .any_o    (any_pend),
    .onehot_o (low_oh),
    .idx_o    (low_idx)
  );

  assign head = entries_i[int'(low_idx)*EW +: EW];

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    result_d = result_q;
    peek_en  = 1'b0;
    finish   = 1'b0;
    probe_o  = '0;
    pop_o    = '0;
    drain_o  = '0;
    hw_val_o = PRIO_OPEN;
    case (st_q)
      SC_IDLE: begin
        if (start_i) begin
          st_d    = SC_PROBE;
          peek_en = 1'b1;
        end
      end
      SC_PROBE: begin
        if (!any_pend) begin
          finish   = 1'b1;
          result_d = '0;
          hw_val_o = PRIO_OPEN;
        end else begin
          probe_o = low_oh;
          if (head != '0) begin
            finish   = 1'b1;
            result_d = head;
            hw_val_o = PRIO_REG_W'(low_idx);
            if (!peek_q) pop_o = low_oh;
          end else begin
            pend_d  = pend_q & ~low_oh;
            drain_o = low_oh;
          end
        end
      end
      default: st_d = SC_IDLE;
    endcase
    if (finish)    st_d   = SC_IDLE;
    if (set_vld_i) pend_d = pend_d | set_mask_i;
  end

  assign hw_wr_o = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SC_IDLE;
      peek_q   <= 1'b0;
      pend_q   <= '0;
      done_q   <= 1'b0;
      replay_q <= 1'b0;
      result_q <= '0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      done_q   <= finish;
      replay_q <= finish && peek_q && (result_d != '0);
      if (peek_en) peek_q   <= peek_i;
      if (finish)  result_q <= result_d;
    end
  end

  assign pend_o   = pend_q;
  assign busy_o   = (st_q == SC_PROBE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign replay_o = replay_q;

  p_probe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_o));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_drain_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_o != '0) && !set_vld_i |=> ((pend_q & $past(drain_o)) == '0));

  p_replay_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    replay_o |-> (done_o && (result_o != '0)));

  p_idle_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: rtl/prio_scan_top.sv
module prio_scan_top
  import prio_scan_pkg::*;
#(
  parameter int NPRIO   = 8,
  parameter int ENTRY_W = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pend_set_vld_i,
  input  logic [NPRIO-1:0]           pend_set_mask_i,
  input  logic                       scan_start_i,
  input  logic                       scan_peek_i,
  input  logic [NPRIO*ENTRY_W-1:0]   q_entry_i,
  output logic [NPRIO-1:0]           q_probe_o,
  output logic [NPRIO-1:0]           q_pop_o,
  output logic [NPRIO-1:0]           q_drain_o,
  input  logic                       cur_prio_wr_i,
  input  logic [7:0]                 cur_prio_wdata_i,
  output logic                       scan_busy_o,
  output logic                       scan_done_o,
  output logic [ENTRY_W-1:0]         scan_result_o,
  output logic                       replay_o,
  output logic [NPRIO-1:0]           pend_mask_o,
  output logic [7:0]                 cur_prio_o,
  output logic                       cur_prio_upd_o,
  output logic                       irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic                  rst_n_s;
  logic                  hw_wr;
  logic [PRIO_REG_W-1:0] hw_val;

  prio_scan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  prio_scan_fsm #(.N(NPRIO), .EW(ENTRY_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (scan_start_i),
    .peek_i     (scan_peek_i),
    .set_vld_i  (pend_set_vld_i),
    .set_mask_i (pend_set_mask_i),
    .entries_i  (q_entry_i),
    .pend_o     (pend_mask_o),
    .probe_o    (q_probe_o),
    .pop_o      (q_pop_o),
    .drain_o    (q_drain_o),
    .busy_o     (scan_busy_o),
    .done_o     (scan_done_o),
    .result_o   (scan_result_o),
    .replay_o   (replay_o),
    .hw_wr_o    (hw_wr),
    .hw_val_o   (hw_val)
  );

  prio_scan_curprio #(.N(NPRIO)) u_cur (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sw_wr_i  (cur_prio_wr_i),
    .sw_val_i (cur_prio_wdata_i),
    .hw_wr_i  (hw_wr),
    .hw_val_i (hw_val),
    .pend_i   (pend_mask_o),
    .cur_o    (cur_prio_o),
    .hw_chg_o (cur_prio_upd_o),
    .irq_o    (irq_o)
  );

  p_empty_opens_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    scan_done_o && (scan_result_o == '0) && !$past(cur_prio_wr_i)
      |-> (cur_prio_o == PRIO_OPEN));

  p_upd_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    cur_prio_upd_o |-> scan_done_o);
endmodule

// File: tb/test_prio_scan_top.sv
module test_prio_scan_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NP = 8;
  localparam int EW = 31;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pend_set_vld = 1'b0;
  logic [NP-1:0]     pend_set_mask = '0;
  logic              scan_start = 1'b0;
  logic              scan_peek = 1'b0;
  logic [NP*EW-1:0]  q_entry;
  logic [NP-1:0]     q_probe, q_pop, q_drain;
  logic              cur_wr = 1'b0;
  logic [7:0]        cur_wdata = '0;
  logic              busy, done, replay, upd, irq;
  logic [EW-1:0]     result;
  logic [NP-1:0]     pend_mask;
  logic [7:0]        cur_prio;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  int fill_cnt [NP];
  int popped   [NP];
  int drains   [NP];

  logic [NP-1:0] exp_mask = '0;
  logic [7:0]    exp_cur  = 8'h00;

  always #5 clk = ~clk;

  prio_scan_top #(.NPRIO(NP), .ENTRY_W(EW)) i_prio_scan_top (
    .clk              (clk),
    .rst_n            (rst_n),
    .pend_set_vld_i   (pend_set_vld),
    .pend_set_mask_i  (pend_set_mask),
    .scan_start_i     (scan_start),
    .scan_peek_i      (scan_peek),
    .q_entry_i        (q_entry),
    .q_probe_o        (q_probe),
    .q_pop_o          (q_pop),
    .q_drain_o        (q_drain),
    .cur_prio_wr_i    (cur_wr),
    .cur_prio_wdata_i (cur_wdata),
    .scan_busy_o      (busy),
    .scan_done_o      (done),
    .scan_result_o    (result),
    .replay_o         (replay),
    .pend_mask_o      (pend_mask),
    .cur_prio_o       (cur_prio),
    .cur_prio_upd_o   (upd),
    .irq_o            (irq)
  );

  function automatic logic [EW-1:0] head_of(int p, int pops);
    return EW'((p + 1) << 20) | EW'(pops & 32'hFFFFF);
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++)
      q_entry[p*EW +: EW] = (fill_cnt[p] > popped[p]) ? head_of(p, popped[p]) : '0;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (q_pop[p])   popped[p] <= popped[p] + 1;
      if (q_drain[p]) drains[p] <= drains[p] + 1;
    end
  end

  function automatic bit exp_irq(logic [NP-1:0] m, logic [7:0] c);
    for (int p = 0; p < NP; p++)
      if (m[p] && (8'(p) < c)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_pend(input logic [NP-1:0] m);
    pend_set_vld  = 1'b1;
    pend_set_mask = m;
    @(negedge clk);
    pend_set_vld  = 1'b0;
    pend_set_mask = '0;
    exp_mask = exp_mask | m;
    chk("R2", "pending vector", pend_mask, exp_mask);
  endtask

  task automatic write_cur(input logic [7:0] v);
    cur_wr    = 1'b1;
    cur_wdata = v;
    @(negedge clk);
    cur_wr = 1'b0;
    exp_cur = v;
    chk("R9", "direct write", cur_prio, v);
    chk("R10", "irq vs register", irq, exp_irq(exp_mask, exp_cur));
  endtask

  // poke: start again while busy (R11); collide: direct write on the finishing edge (R9)
  task automatic do_scan(input bit peek, input bit poke, input bit collide, input logic [7:0] cval);
    logic [NP-1:0] m;
    int            empties, lat, fprio;
    bit            found;
    logic [EW-1:0] eres;
    logic [7:0]    ecur, old_cur;
    int            pop0 [NP];
    int            drn0 [NP];
    int            edrn [NP];
    m = exp_mask; empties = 0; found = 1'b0; eres = '0; fprio = -1;
    for (int p = 0; p < NP; p++) begin
      pop0[p] = popped[p];
      drn0[p] = drains[p];
      edrn[p] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      if (!found && m[p]) begin
        if (fill_cnt[p] > popped[p]) begin
          found = 1'b1; eres = head_of(p, popped[p]); fprio = p;
        end else begin
          m[p] = 1'b0; empties++; edrn[p] = 1;
        end
      end
    end
    old_cur = exp_cur;
    ecur = found ? 8'(fprio) : 8'hFF;

    scan_start = 1'b1;
    scan_peek  = peek;
    @(negedge clk);
    scan_start = poke;
    if (collide) begin cur_wr = 1'b1; cur_wdata = cval; end
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 2) begin scan_start = 1'b0; cur_wr = 1'b0; end
    end
    scan_start = 1'b0;
    cur_wr = 1'b0;

    chk("R3", "done latency", lat, empties + 2);
    chk("R3", "result entry", result, eres);
    chk("R8", "replay", replay, peek && found);
    if (collide) begin
      chk("R9", "write beats scan", cur_prio, cval);
      chk("R9", "no update pulse", upd, 0);
      exp_cur = cval;
    end else begin
      if (!found) chk("R5", "register opened", cur_prio, 8'hFF);
      else        chk("R6", "register set to found priority", cur_prio, ecur);
      chk("R6", "update pulse only on change", upd, ecur != old_cur);
      exp_cur = ecur;
    end
    chk("R4", "empty bits cleared", pend_mask, m);
    for (int p = 0; p < NP; p++) begin
      chk("R4", $sformatf("drain strobes prio %0d", p), drains[p] - drn0[p], edrn[p]);
      chk("R7", $sformatf("pops prio %0d", p), popped[p] - pop0[p],
          (found && !peek && p == fprio) ? 1 : 0);
    end
    exp_mask = m;
    @(negedge clk);
    chk("R11", "no second done", done, 0);
    chk("R11", "idle after scan", busy, 0);
    chk("R10", "irq after scan", irq, exp_irq(exp_mask, exp_cur));
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin fill_cnt[p] = 0; popped[p] = 0; drains[p] = 0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "pending after reset", pend_mask, 0);
    chk("R1", "register after reset", cur_prio, 8'h00);
    chk("R1", "done after reset", done, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "replay after reset", replay, 0);
    chk("R1", "irq after reset", irq, 0);

    // R10 gating by the register value
    set_pend(8'b0010_0100);
    write_cur(8'h00);
    write_cur(8'hFF);
    write_cur(8'h02);
    write_cur(8'h03);

    // R3/R4: stale bit 2 below live queue 5
    fill_cnt[5] = 1;
    do_scan(1'b1, 1'b0, 1'b0, 8'h00);   // peek: replay, no pop (R7, R8)
    do_scan(1'b1, 1'b0, 1'b0, 8'h00);   // same result, no change pulse (R6)
    do_scan(1'b0, 1'b1, 1'b0, 8'h00);   // consume, with a start while busy (R11)
    do_scan(1'b1, 1'b0, 1'b0, 8'h00);   // queue 5 now empty: result 0, 0xFF (R5)
    // R9: direct write on the same edge as a finishing empty scan
    do_scan(1'b0, 1'b0, 1'b1, 8'h05);

    for (int it = 0; it < 300; it++) begin
      logic [NP-1:0] sm;
      sm = NP'($urandom);
      if ($urandom_range(3) != 0) set_pend(sm);
      for (int p = 0; p < NP; p++)
        if ($urandom_range(3) == 0) fill_cnt[p] = fill_cnt[p] + int'($urandom_range(2));
      if ($urandom_range(4) == 0) write_cur(8'($urandom_range(9)));
      if (exp_mask == '0 && $urandom_range(3) == 0)
        do_scan(1'($urandom), 1'b0, 1'b1, 8'($urandom));
      else
        do_scan(1'($urandom), 1'($urandom), 1'b0, 8'h00);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule